// File: doc/BRIEF.md
# Self-Routing Shuffle-Exchange Interconnect

This block joins a power-of-two number of requesters to the same number of targets through a cascade of 2x2 switch columns. Each column first permutes its lanes with a perfect shuffle, which is a one-bit left rotation of the lane index. Its switches then set themselves from a single bit of each request's target index. No central controller is involved. A request placed on input lane i with target d appears on output port d after a fixed pipeline delay, with its payload intact.

The network is blocking. When two live requests meet in one switch and both need the same switch output, the request on the upper lane keeps the output. The other request is marked as lost. It still moves through the remaining columns, but it no longer competes for any switch output and it never reaches a port. For every input lane the block reports, aligned with the output ports, whether that lane's request was delivered or blocked. A caller can then decide to resend a blocked request. Resending is outside this block.

Top module: `omega_net`

## Requirements
- R1: While reset is held, and before any request has had time to reach the end of the pipeline, `out_valid`, `out_data`, `req_blocked` and `req_delivered` are all zero.
- R2: A request that is not blocked, presented on lane i with target d, shows up exactly log2(NPORT) clock cycles later as `out_valid[d]`=1. Its payload appears unchanged on `out_data[d*DW +: DW]`, and `req_delivered[i]`=1 in the same cycle.
- R3: Column k (k = 0 is next to the inputs) shuffles lane j to lane ((j<<1)|(j>>(log2(NPORT)-1))) mod NPORT. It then sends each request to the even lane of its switch pair when target bit log2(NPORT)-1-k is 0, and to the odd lane when that bit is 1. A lone request always reaches its target port.
- R4: When two live requests in one switch need the same output, the request on the even (upper) input lane wins. The other request's `req_blocked` flag is 1 exactly log2(NPORT) cycles after it entered.
- R5: In each cycle, every lane that was valid log2(NPORT) cycles earlier has exactly one of `req_blocked` or `req_delivered` set. A lane that was idle has neither, and the two flags are never both set.
- R6: The identity pattern (every lane i targets i) produces no blocking, and all requests are delivered.
- R7: A fresh set of requests may be presented every cycle. Each set is routed and flagged independently of the sets before and after it.
- R8: An output port that receives no live request shows `out_valid`=0 and a zero payload. Idle input lanes and blocked requests never light a port.
- R9: A request that has already lost does not compete in later columns, so it cannot block any live request downstream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pipeline registers update on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NPORT | Per-lane request present |
| in_dest | input | NPORT*log2(NPORT) | Per-lane target port index, lane i in bits i*AW +: AW |
| in_data | input | NPORT*DW | Per-lane payload, lane i in bits i*DW +: DW |
| out_valid | output | NPORT | Per-port delivered request present |
| out_data | output | NPORT*DW | Per-port payload, port d in bits d*DW +: DW, zero when idle |
| req_blocked | output | NPORT | Per-input-lane: request lost to contention (delayed by log2(NPORT)) |
| req_delivered | output | NPORT | Per-input-lane: request reached its port (delayed by log2(NPORT)) |

## Verification
A switch that sets its configuration wrongly, or a miswired shuffle, sends a payload to the wrong port. The error shows on `out_valid`/`out_data` in the first cycle in which that request leaves the pipeline, log2(NPORT) cycles after injection. A wrong priority, or a lost flag that is dropped or leaks, changes which lane's flag is set in that same exit cycle. Because a fresh pattern enters every cycle, any state carried across sets also shows up within one pipeline depth.

// File: rtl/omega_pkg.sv
package omega_pkg;

  typedef enum logic {
    SW_PASS  = 1'b0,
    SW_CROSS = 1'b1
  } sw_cfg_e;

  // lane index after the perfect-shuffle wiring: one-bit left rotation
  function automatic int unsigned shuffle_lane(input int unsigned j, input int unsigned aw);
    int unsigned msk;
    msk = (32'd1 << aw) - 32'd1;
    return ((j << 1) | (j >> (aw - 1))) & msk;
  endfunction

  // target bit consulted by column k
  function automatic int unsigned steer_bit(input int unsigned k, input int unsigned aw);
    return aw - 1 - k;
  endfunction

endpackage

// File: rtl/omega_switch.sv
module omega_switch
  import omega_pkg::*;
#(
  parameter int AW  = 3,
  parameter int DW  = 8,
  parameter int BIT = 2
) (
  input  logic [DW+2*AW+1:0] up_i,
  input  logic [DW+2*AW+1:0] lo_i,
  output logic [DW+2*AW+1:0] up_o,
  output logic [DW+2*AW+1:0] lo_o,
  output sw_cfg_e            cfg_o,
  output logic               clash_o
);
  localparam int PW   = DW + 2*AW + 2;
  localparam int VLD  = PW - 1;
  localparam int LIVE = PW - 2;
  localparam int TBIT = DW + BIT;

  logic up_ok, lo_ok, up_want, lo_want;
  logic [PW-1:0] lo_fwd;

  always_comb begin
    up_ok   = up_i[VLD] & up_i[LIVE];
    lo_ok   = lo_i[VLD] & lo_i[LIVE];
    up_want = up_i[TBIT];
    lo_want = lo_i[TBIT];
    clash_o = up_ok & lo_ok & (up_want == lo_want);
    if (up_ok)      cfg_o = up_want ? SW_CROSS : SW_PASS;
    else if (lo_ok) cfg_o = lo_want ? SW_PASS : SW_CROSS;
    else            cfg_o = SW_PASS;
    lo_fwd = lo_i;
    if (clash_o) lo_fwd[LIVE] = 1'b0;   // lower lane loses, keeps travelling dead
    if (cfg_o == SW_CROSS) begin
      up_o = lo_fwd;
      lo_o = up_i;
    end else begin
      up_o = up_i;
      lo_o = lo_fwd;
    end
  end
endmodule

// File: rtl/omega_stage.sv
module omega_stage
  import omega_pkg::*;
#(
  parameter int NPORT = 8,
  parameter int AW    = 3,
  parameter int DW    = 8,
  parameter int K     = 0
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NPORT*(DW+2*AW+2)-1:0]   slot_i,
  output logic [NPORT*(DW+2*AW+2)-1:0]   slot_o,
  output logic [NPORT/2-1:0]             clash_o
);
  localparam int PW   = DW + 2*AW + 2;
  localparam int HALF = NPORT / 2;
  localparam int BIT  = int'(steer_bit(K, AW));

  logic [NPORT*PW-1:0] shuf;
  logic [NPORT*PW-1:0] swout;

  for (genvar j = 0; j < NPORT; j++) begin : g_wire
    localparam int SJ = int'(shuffle_lane(j, AW));
    assign shuf[SJ*PW +: PW] = slot_i[j*PW +: PW];
  end

  for (genvar m = 0; m < HALF; m++) begin : g_sw
    sw_cfg_e cfg;
    omega_switch #(.AW(AW), .DW(DW), .BIT(BIT)) u_sw (
      .up_i   (shuf[(2*m)*PW +: PW]),
      .lo_i   (shuf[(2*m+1)*PW +: PW]),
      .up_o   (swout[(2*m)*PW +: PW]),
      .lo_o   (swout[(2*m+1)*PW +: PW]),
      .cfg_o  (cfg),
      .clash_o(clash_o[m])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) slot_o <= '0;
    else        slot_o <= swout;
  end
endmodule

// File: rtl/omega_net.sv
module omega_net
  import omega_pkg::*;
#(
  parameter int NPORT = 8,
  parameter int DW    = 8,
  parameter int AW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORT-1:0]     in_valid,
  input  logic [NPORT*AW-1:0]  in_dest,
  input  logic [NPORT*DW-1:0]  in_data,
  output logic [NPORT-1:0]     out_valid,
  output logic [NPORT*DW-1:0]  out_data,
  output logic [NPORT-1:0]     req_blocked,
  output logic [NPORT-1:0]     req_delivered
);
  localparam int PW     = DW + 2*AW + 2;
  localparam int STAGES = AW;
  localparam int HALF   = NPORT / 2;
  localparam int VLD    = PW - 1;
  localparam int LIVE   = PW - 2;
  localparam int SRC    = DW + AW;

  logic [NPORT*PW-1:0]      stage_slots [STAGES+1];
  logic [NPORT*PW-1:0]      tail_slots;
  logic [STAGES*HALF-1:0]   clash_all;

  // slot layout: {valid, live, source lane, target, payload}
  for (genvar i = 0; i < NPORT; i++) begin : g_inj
    assign stage_slots[0][i*PW +: PW] =
      {in_valid[i], in_valid[i], AW'(i), in_dest[i*AW +: AW], in_data[i*DW +: DW]};
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_col
    omega_stage #(.NPORT(NPORT), .AW(AW), .DW(DW), .K(k)) u_col (
      .clk    (clk),
      .rst_n  (rst_n),
      .slot_i (stage_slots[k]),
      .slot_o (stage_slots[k+1]),
      .clash_o(clash_all[k*HALF +: HALF])
    );
  end

  assign tail_slots = stage_slots[STAGES];

  always_comb begin
    out_valid     = '0;
    out_data      = '0;
    req_blocked   = '0;
    req_delivered = '0;
    for (int s = 0; s < NPORT; s++) begin
      logic [PW-1:0] sl;
      sl = tail_slots[s*PW +: PW];
      if (sl[VLD]) begin
        if (sl[LIVE]) begin
          out_valid[s]              = 1'b1;
          out_data[s*DW +: DW]      = sl[DW-1:0];
          req_delivered[sl[SRC +: AW]] = 1'b1;
        end else begin
          req_blocked[sl[SRC +: AW]]   = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/omega_net_chk.sv
module omega_net_chk #(
  parameter int NPORT = 8,
  parameter int AW    = 3,
  parameter int DW    = 8
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [NPORT-1:0]                in_valid,
  input logic [NPORT-1:0]                out_valid,
  input logic [NPORT-1:0]                req_blocked,
  input logic [NPORT-1:0]                req_delivered,
  input logic [NPORT*(DW+2*AW+2)-1:0]    tail,
  input logic [AW*(NPORT/2)-1:0]         clash
);
  localparam int PW   = DW + 2*AW + 2;
  localparam int HALF = NPORT / 2;
  localparam int L    = AW;

  logic [NPORT-1:0] vhist [L];
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < L; k++) vhist[k] <= '0;
    end else begin
      vhist[0] <= in_valid;
      for (int k = 1; k < L; k++) vhist[k] <= vhist[k-1];
    end
  end

  wire last_clash = |clash[(L-1)*HALF +: HALF];

  AST_FLAGS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_blocked & req_delivered) == '0);                                // R5
  AST_FLAGS_TRACK_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_blocked | req_delivered) == vhist[L-1]);                        // R2
  AST_PORTS_MATCH_DELIVERED: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_valid) == $countones(req_delivered));                 // R8
  AST_LAST_CLASH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    last_clash |=> (req_blocked != '0));                                 // R4

  for (genvar s = 0; s < NPORT; s++) begin : g_port
    AST_PORT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[s] |-> (tail[s*PW+DW +: AW] == AW'(s)));                 // R3
  end
endmodule

bind omega_net omega_net_chk #(.NPORT(NPORT), .AW(AW), .DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .out_valid    (out_valid),
  .req_blocked  (req_blocked),
  .req_delivered(req_delivered),
  .tail         (tail_slots),
  .clash        (clash_all)
);

// File: tb/omega_net_test.sv
`timescale 1ns/1ps
module omega_net_test;
  localparam int P = 8;
  localparam int A = 3;
  localparam int D = 8;
  localparam int L = A;
  localparam int RING = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [P-1:0]   in_valid = '0;
  logic [P*A-1:0] in_dest  = '0;
  logic [P*D-1:0] in_data  = '0;
  logic [P-1:0]   out_valid;
  logic [P*D-1:0] out_data;
  logic [P-1:0]   req_blocked;
  logic [P-1:0]   req_delivered;

  always #2 clk = ~clk;   // 250 MHz

  omega_net #(.NPORT(P), .DW(D), .AW(A)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .req_blocked(req_blocked), .req_delivered(req_delivered)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  int         dsel [P];
  logic [P-1:0] vsel;
  bit         ident_now;

  logic [P-1:0]   e_ov [RING];
  logic [P*D-1:0] e_od [RING];
  logic [P-1:0]   e_bl [RING];
  logic [P-1:0]   e_dl [RING];
  bit             e_id [RING];

  task automatic cmp(input string req, input string what, input logic [P*D-1:0] act,
                     input logic [P*D-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d: actual %h expected %h", req, what, cyc, act, exp);
    end
  endtask

  // Reference: a live request sits on lane ({src,target} >> (A-1-k)) mod P after
  // column k; the winner of a shared output is the one with source bit A-1-k clear.
  // Dead requests take no part (R9).
  task automatic model(input int slot);
    bit alive [P];
    bit snap  [P];
    int pos   [P];
    for (int i = 0; i < P; i++) alive[i] = vsel[i];
    for (int k = 0; k < A; k++) begin
      for (int i = 0; i < P; i++) begin
        snap[i] = alive[i];
        pos[i]  = (((i << A) | dsel[i]) >> (A - 1 - k)) & (P - 1);
      end
      for (int i = 0; i < P; i++)
        for (int j = i + 1; j < P; j++)
          if (snap[i] && snap[j] && pos[i] == pos[j]) begin
            if (((i >> (A - 1 - k)) & 1) == 0) alive[j] = 1'b0;
            else                                alive[i] = 1'b0;
          end
    end
    e_ov[slot] = '0; e_od[slot] = '0; e_bl[slot] = '0; e_dl[slot] = '0;
    for (int i = 0; i < P; i++) begin
      if (alive[i]) begin
        e_ov[slot][dsel[i]] = 1'b1;
        e_od[slot][dsel[i]*D +: D] = in_data[i*D +: D];
        e_dl[slot][i] = 1'b1;
      end else if (vsel[i]) begin
        e_bl[slot][i] = 1'b1;
      end
    end
    e_id[slot] = ident_now;
  endtask

  // one cycle: check what entered L cycles ago, then drive the next set (R7)
  task automatic step();
    if (cyc >= L) begin
      int s;
      s = (cyc - L) % RING;
      cmp("R8", "out_valid",     {{(P*D-P){1'b0}}, out_valid},     {{(P*D-P){1'b0}}, e_ov[s]});
      cmp("R2/R3", "out_data",   out_data, e_od[s]);
      cmp("R5", "req_delivered", {{(P*D-P){1'b0}}, req_delivered}, {{(P*D-P){1'b0}}, e_dl[s]});
      cmp("R4/R9", "req_blocked",{{(P*D-P){1'b0}}, req_blocked},   {{(P*D-P){1'b0}}, e_bl[s]});
      if (e_id[s]) cmp("R6", "identity blocked", {{(P*D-P){1'b0}}, req_blocked}, '0);
    end
    in_valid = vsel;
    for (int i = 0; i < P; i++) begin
      in_dest[i*A +: A] = A'(dsel[i]);
      in_data[i*D +: D] = D'((cyc * 37 + i * 11) ^ 8'h5a);
    end
    model(cyc % RING);
    cyc++;
    @(negedge clk);
  endtask

  initial begin
    #(4ns * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    ident_now = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet under reset
    cmp("R1", "reset out_valid", {{(P*D-P){1'b0}}, out_valid}, '0);
    cmp("R1", "reset out_data", out_data, '0);
    cmp("R1", "reset flags", {{(P*D-2*P){1'b0}}, req_blocked, req_delivered}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 identity
    vsel = '1; ident_now = 1'b1;
    for (int i = 0; i < P; i++) dsel[i] = i;
    step();
    ident_now = 1'b0;
    // bit reversal
    for (int i = 0; i < P; i++) dsel[i] = ((i & 1) << 2) | (i & 2) | ((i >> 2) & 1);
    step();
    // xor and rotation families
    for (int c = 0; c < P; c++) begin
      for (int i = 0; i < P; i++) dsel[i] = i ^ c;
      step();
      for (int i = 0; i < P; i++) dsel[i] = (i + c) % P;
      step();
      for (int i = 0; i < P; i++) dsel[i] = c;   // hot spot, R4
      step();
    end
    // R3: every lone request reaches its port
    for (int i = 0; i < P; i++)
      for (int d = 0; d < P; d++) begin
        vsel = '0; vsel[i] = 1'b1;
        for (int j = 0; j < P; j++) dsel[j] = (j * 3 + d) % P;
        dsel[i] = d;
        step();
      end
    // R7/R8/R9: random targets and random idle lanes, back to back
    for (int n = 0; n < 3000; n++) begin
      vsel = P'($urandom);
      for (int i = 0; i < P; i++) dsel[i] = int'($urandom % P);
      step();
    end
    vsel = '0;
    for (int n = 0; n < L + 1; n++) step();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule